// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is an independent watchdog for a single clock domain. Software starts it by writing a start key to the key register. After that the down-counter runs and cannot be stopped by any register access. Software must write a reload key before the count passes zero. If it does not, the block pulses a reset-request output for one cycle, loads the count again and keeps running.

An early-warning interrupt can be armed ahead of expiry. When the running count equals a programmed compare value, a pending flag is set and drives the interrupt output. A wake controller or an interrupt handler then reloads the counter, or acknowledges the flag by writing a clear bit.

The register bus is a plain write strobe with an address and 32-bit write data. Read data is combinational from the address and carries the running state, the count, the reload value and the early-warning settings.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the watchdog is stopped. Offset 0x04 reads 0, offset 0x08 reads all ones in its CNT_W-bit field, offset 0x14 reads 0, and irq and rst_req are low.
- R2: A write of exactly 0x0000CCCC to offset 0x00 starts the watchdog. The running bit (bit 16 of offset 0x04) goes to 1 and the count (bits CNT_W-1:0 of offset 0x04) is loaded from the reload register. Repeating the start key while running leaves the count unaffected.
- R3: Once running, the watchdog never stops, and the count drops by one on every clock cycle.
- R4: A write of exactly 0x0000AAAA to offset 0x00 while running loads the count from the reload register and clears a pending early warning. Before start it has no effect.
- R5: Any other value written to offset 0x00 has no effect on the running state or the count.
- R6: When the count is 0 while running and no reload key is written, rst_req is high for exactly the next cycle. In that cycle the count holds the reload value, and counting continues.
- R7: With the enable bit (bit 15 of offset 0x14) set, irq rises in the cycle after the running count equals the compare field (bits CNT_W-1:0 of offset 0x14). With the enable bit clear, irq does not rise.
- R8: irq stays high, including across an expiry, until a write to offset 0x14 with bit 14 set, or a reload key. A compare match in the same cycle as the acknowledge write leaves irq set.
- R9: The reload register (CNT_W bits at offset 0x08) reads back what was written. Offset 0x14 reads the compare field in its low bits, the pending flag at bit 14 and the enable at bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with CNT_W = 6, so the reload and compare fields are six bits wide. A reload value of 10 gives a full period of eleven cycles. Several expiries, compare matches on both sides of an expiry, and an acknowledge that lands on the exact match cycle therefore occur within a few hundred cycles. The smaller width exercises the same field positions and key decoding as the default twelve-bit width.

// File: rtl/wdg_keyed_pkg.sv
package wdg_keyed_pkg;
   typedef enum logic [7:0] {
      OFS_KEY = 8'h00,
      OFS_CNT = 8'h04,
      OFS_RLD = 8'h08,
      OFS_EWC = 8'h14
   } wdg_ofs_e;

   localparam logic [31:0] KEY_START_DEF  = 32'h0000_CCCC;
   localparam logic [31:0] KEY_RELOAD_DEF = 32'h0000_AAAA;

   localparam int unsigned EWC_ACK_BIT = 14;
   localparam int unsigned EWC_EN_BIT  = 15;
   localparam int unsigned CNT_RUN_BIT = 16;
endpackage

// File: rtl/wdg_keyed_regs.sv
module wdg_keyed_regs
   import wdg_keyed_pkg::*;
#(
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned ADDR_W     = 8,
   parameter logic [31:0] START_KEY  = KEY_START_DEF,
   parameter logic [31:0] RELOAD_KEY = KEY_RELOAD_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              run,
   input  logic              ew_flag,
   output logic [CNT_W-1:0]  rld,
   output logic [CNT_W-1:0]  cmp,
   output logic              ew_en,
   output logic              start_req,
   output logic              reload_req,
   output logic              ew_ack
);
   logic hit_key, hit_rld, hit_ewc;

   assign hit_key = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
   assign hit_rld = bus_wr && (bus_addr == ADDR_W'(OFS_RLD));
   assign hit_ewc = bus_wr && (bus_addr == ADDR_W'(OFS_EWC));

   assign start_req  = hit_key && (bus_wdata == START_KEY);
   assign reload_req = hit_key && (bus_wdata == RELOAD_KEY);
   assign ew_ack     = hit_ewc && bus_wdata[EWC_ACK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld   <= '1;
         cmp   <= '0;
         ew_en <= 1'b0;
      end else begin
         if (hit_rld) rld <= bus_wdata[CNT_W-1:0];
         if (hit_ewc) begin
            cmp   <= bus_wdata[CNT_W-1:0];
            ew_en <= bus_wdata[EWC_EN_BIT];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CNT): begin
            bus_rdata[CNT_W-1:0]   = cnt;
            bus_rdata[CNT_RUN_BIT] = run;
         end
         ADDR_W'(OFS_RLD): bus_rdata[CNT_W-1:0] = rld;
         ADDR_W'(OFS_EWC): begin
            bus_rdata[CNT_W-1:0]   = cmp;
            bus_rdata[EWC_ACK_BIT] = ew_flag;
            bus_rdata[EWC_EN_BIT]  = ew_en;
         end
         default: bus_rdata = '0;
      endcase
   end

   // R5
   key_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_req && reload_req));
endmodule

// File: rtl/wdg_keyed_counter.sv
module wdg_keyed_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             reload_req,
   input  logic [CNT_W-1:0] rld,
   output logic [CNT_W-1:0] cnt,
   output logic             run,
   output logic             expire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         run    <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (!run) begin
            if (start_req) begin
               run <= 1'b1;
               cnt <= rld;
            end
         end else if (reload_req) begin
            cnt <= rld;
         end else if (cnt == '0) begin
            cnt    <= rld;
            expire <= 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R3
   run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run);
   // R2
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start_req) |=> (cnt == $past(cnt)));
   // R4
   reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && reload_req) |=> (cnt == $past(rld)));
   // R6
   expire_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (run && cnt == $past(rld)));
endmodule

// File: rtl/wdg_keyed_early.sv
module wdg_keyed_early #(
   parameter int unsigned CNT_W    = 12,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             ew_en,
   input  logic             reload_req,
   input  logic             ew_ack,
   output logic             flag
);
   logic match, clr, flag_d;

   assign match = run && ew_en && (cnt == cmp) && !reload_req;
   assign clr   = ew_ack || reload_req;

   generate
      if (SET_WINS) begin : g_set_wins
         assign flag_d = match || (flag && !clr);
      end else begin : g_clr_wins
         assign flag_d = (match || flag) && !clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_d;
   end

   // R7
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(run && ew_en && cnt == cmp));
   // R4
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> !flag);
   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ew_ack && !(run && ew_en && cnt == cmp)) |=> !flag);
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
   import wdg_keyed_pkg::*;
#(
   parameter int unsigned CNT_W      = 12,
   parameter int unsigned ADDR_W     = 8,
   parameter logic [31:0] START_KEY  = KEY_START_DEF,
   parameter logic [31:0] RELOAD_KEY = KEY_RELOAD_DEF,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              rst_req
);
   generate
      if (CNT_W < 1 || CNT_W > EWC_ACK_BIT) begin : g_bad_cnt_w
         $error("CNT_W must be within 1..14 so fields do not overlap control bits");
      end
      if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W must be within 5..32 to decode all offsets");
      end
      if (START_KEY == RELOAD_KEY) begin : g_bad_keys
         $error("start and reload keys must differ");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, rld, cmp;
   logic             run, ew_en, ew_flag, start_req, reload_req, ew_ack, expire;

   wdg_keyed_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .START_KEY(START_KEY), .RELOAD_KEY(RELOAD_KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .run(run),
      .ew_flag(ew_flag), .rld(rld), .cmp(cmp), .ew_en(ew_en),
      .start_req(start_req), .reload_req(reload_req), .ew_ack(ew_ack)
   );

   wdg_keyed_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload_req(reload_req),
      .rld(rld), .cnt(cnt), .run(run), .expire(expire)
   );

   wdg_keyed_early #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_early (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .cmp(cmp), .ew_en(ew_en),
      .reload_req(reload_req), .ew_ack(ew_ack), .flag(ew_flag)
   );

   assign irq     = ew_flag;
   assign rst_req = expire;

   // R6
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(run && cnt == '0));
endmodule

// File: tb/wdg_keyed_tb.sv
module wdg_keyed_tb;
   localparam int CLK_P = 10;
   localparam int CW    = 6;
   localparam int MASK  = (1 << CW) - 1;
   localparam logic [31:0] K_START  = 32'h0000_CCCC;
   localparam logic [31:0] K_RELOAD = 32'h0000_AAAA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h04;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, rst_req;

   int checks = 0;
   int errors = 0;
   int m_run = 0, m_cnt = 0, m_rld = MASK, m_cmp = 0, m_en = 0, m_flag = 0, m_rst = 0;
   int rst_seen = 0;

   always #(CLK_P/2) clk = ~clk;

   wdg_keyed #(.CNT_W(CW), .ADDR_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic expect_eq(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model(input bit w, input logic [7:0] a, input logic [31:0] d);
      bit key, st, rl, ev, ack;
      int n_run, n_cnt, n_rst, n_flag;
      key = w && a == 8'h00;
      st  = key && d == K_START;
      rl  = key && d == K_RELOAD;
      ack = w && a == 8'h14 && d[14];
      n_run = m_run; n_cnt = m_cnt; n_rst = 0;
      if (m_run == 0) begin
         if (st) begin n_run = 1; n_cnt = m_rld; end
      end else if (rl) n_cnt = m_rld;
      else if (m_cnt == 0) begin n_cnt = m_rld; n_rst = 1; end
      else n_cnt = m_cnt - 1;
      ev = m_run != 0 && !rl && m_en != 0 && m_cnt == m_cmp;
      n_flag = (ev || (m_flag != 0 && !(ack || rl))) ? 1 : 0;
      if (w && a == 8'h08) m_rld = int'(d) & MASK;
      if (w && a == 8'h14) begin m_cmp = int'(d) & MASK; m_en = d[15] ? 1 : 0; end
      m_run = n_run; m_cnt = n_cnt; m_rst = n_rst; m_flag = n_flag;
      rst_seen += n_rst;
   endtask

   task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d);
      bus_wr = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model(w, a, d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'h04; bus_wdata = '0;
      #1;
      expect_eq("R3", "count/run", int'(bus_rdata), (m_run << 16) | m_cnt);
      expect_eq("R6", "rst_req", int'(rst_req), m_rst);
      expect_eq("R7", "irq", int'(irq), m_flag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 8'h04, 32'h0);
   endtask

   task automatic read_chk(input string tag, input logic [7:0] a, input int exp);
      bus_addr = a;
      #1;
      expect_eq(tag, "read", int'(bus_rdata), exp);
      bus_addr = 8'h04;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired (R1 sequence incomplete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      read_chk("R1", 8'h04, 0);
      read_chk("R1", 8'h08, MASK);
      read_chk("R1", 8'h14, 0);
      expect_eq("R1", "irq", int'(irq), 0);
      expect_eq("R1", "rst_req", int'(rst_req), 0);

      // R4 reload key before start is ignored
      cyc(1'b1, 8'h00, K_RELOAD);
      read_chk("R4", 8'h04, 0);

      // R9 reload register readback
      cyc(1'b1, 8'h08, 32'hFFFF_FF0A);
      read_chk("R9", 8'h08, 10);

      // R5 other key values leave it stopped
      cyc(1'b1, 8'h00, 32'h0000_1234);
      cyc(1'b1, 8'h00, 32'h0001_CCCC);
      read_chk("R5", 8'h04, 0);

      // R9 early-warning control readback
      cyc(1'b1, 8'h14, 32'h0000_8004);
      read_chk("R9", 8'h14, 32'h8004);

      // R2 start
      cyc(1'b1, 8'h00, K_START);
      expect_eq("R2", "started", int'(bus_rdata), (1 << 16) | 10);
      idle(2);
      cyc(1'b1, 8'h00, K_START);
      expect_eq("R2", "restart ignored", int'(bus_rdata), (1 << 16) | 7);

      // R7 early warning rises after match at count 4
      idle(4);
      expect_eq("R7", "irq after match", int'(irq), 1);
      read_chk("R9", 8'h14, 32'hC004);

      // R8 acknowledge
      cyc(1'b1, 8'h14, 32'h0000_C004);
      expect_eq("R8", "irq after ack", int'(irq), 0);

      // R6 run through expiries
      idle(30);
      expect_eq("R6", "expiries seen", int'(rst_seen > 1), 1);

      // R4 reload while running clears pending
      while (m_flag == 0) idle(1);
      cyc(1'b1, 8'h00, K_RELOAD);
      expect_eq("R4", "irq after reload", int'(irq), 0);
      expect_eq("R4", "count after reload", int'(bus_rdata), (1 << 16) | 10);

      // R5 junk key while running
      cyc(1'b1, 8'h00, 32'h0000_AAAB);
      expect_eq("R5", "junk key", int'(bus_rdata), (1 << 16) | 9);

      // R7 disabled: no interrupt
      cyc(1'b1, 8'h14, 32'h0000_0004);
      idle(30);
      expect_eq("R7", "irq disabled", int'(irq), 0);

      // R8 ack on the match cycle: set wins
      cyc(1'b1, 8'h14, 32'h0000_8004);
      while (m_cnt != 4) idle(1);
      cyc(1'b1, 8'h14, 32'h0000_C004);
      expect_eq("R8", "set wins over ack", int'(irq), 1);

      // R8 flag survives expiry
      idle(12);
      expect_eq("R8", "irq across expiry", int'(irq), 1);

      // R3 long unattended run
      idle(60);
      expect_eq("R3", "still running", int'(bus_rdata[16]), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule